// File: doc/BRIEF.md
# Framed Serial Result Transmitter

This block sends 16-bit conversion results out of a chip over a three-wire serial link, and it is always the link master. A parallel result arrives with a one-cycle valid strobe and is held in a staging register. At each frame boundary the staged word moves into a shift register. The block makes the bit clock, the serial data and the frame sync itself, all from the one system clock. One bit period is two system clock cycles: the bit clock toggles on every clock edge, and every output change is gated by a clock enable on the launching phase.

Configuration pins set three things:
- the frame length: 16 bit periods, or 32 bit periods with a zero-filled tail;
- which bit-clock edge launches data;
- the frame sync shape in long frames: a one-bit pulse or a half-frame-low square wave.

An optional synchronous sync input aligns the frame to an outside event, but only the first accepted pulse after reset does so. That pulse aborts the current frame and restarts it from the staged word. It also gives a one-cycle restart pulse to the upstream filter and raises a settling flag for a fixed number of frames.

A data-line enable output lets two transmitters alternate their words on one shared wire. The output is high only when the two selection inputs agree.

Top module: `frame_serial_tx`

## Requirements
- R1: Each frame carries the staged 16-bit word on ser_data, most significant bit in bit period 0 and least significant bit in bit period 15.
- R2: A bit period lasts two clock cycles and bit_clk toggles every cycle. A frame lasts 16 bit periods when long_frame is 0 and 32 when it is 1, and frames follow each other with no gap.
- R3: With long_frame = 1, ser_data is 0 in bit periods 16 to 31.
- R4: ser_data and frame_sync change only on the clock edge where bit_clk goes to 1 when launch_fall = 0, or goes to 0 when launch_fall = 1. They hold during the other half of the bit period.
- R5: frame_sync is high only in bit period 0 when long_frame = 0 or sq_sync = 0. With long_frame = 1 and sq_sync = 1 it is low in bit periods 0 to 15 and high in bit periods 16 to 31.
- R6: The first sync_in sample accepted after reset aborts the frame in progress. filt_restart is then high for the one cycle after the sampling edge, and bit_clk rests at its idle level (equal to launch_fall). A new frame with the staged word starts on the next edge.
- R7: Once one sync_in has been accepted, later sync_in pulses change neither the frame timing nor filt_restart.
- R8: With long_frame = 1 and sq_sync = 0, sync_in is ignored and does not use up the single accepted sync.
- R9: ser_oe is 1 exactly when line_sel equals slot_id.
- R10: settling goes high with filt_restart and stays high through SETTLE_FRAMES frames, counting the restarted frame as the first. It falls on the launch edge that starts the next frame after those.
- R11: If no new result arrives, the previous word is sent again in the next frame.
- R12: While rst_n is low: bit_clk equals launch_fall, and ser_data, frame_sync, filt_restart and settling are 0 (frame_sync in pulse format).
- R13: A result strobed during a frame does not disturb that frame. It is sent from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| res_data | input | WORD_W | Parallel result word |
| res_valid | input | 1 | One-cycle strobe that stages res_data |
| long_frame | input | 1 | 1 selects 32-bit-period frames, 0 selects 16 |
| launch_fall | input | 1 | 1 launches data on the falling bit_clk edge |
| sq_sync | input | 1 | 1 selects the square frame sync in long frames |
| sync_in | input | 1 | Synchronous frame alignment request |
| line_sel | input | 1 | Data-line enable level |
| slot_id | input | 1 | Slot identity compared with line_sel |
| bit_clk | output | 1 | Serial bit clock |
| ser_data | output | 1 | Serial data |
| ser_oe | output | 1 | Drive enable for the shared data-line buffer |
| frame_sync | output | 1 | Frame sync |
| filt_restart | output | 1 | One-cycle filter restart pulse |
| settling | output | 1 | Results still invalid after a restart |

## Verification
The bench sends words through every mix of frame length, launch edge and sync shape:
- Alternating bit patterns expose bit-order or shift errors.
- Single set bits at each end catch off-by-one framing.
- An all-ones word against the zero tail shows that the data and the padding are kept apart.

Sync pulses go in mid-frame three ways: in the pulse format, where they must do nothing; first in the square format, where they must restart; and a second time, where they must not. Comparing the frame-start spacing across these three cases tells an abort apart from an undisturbed frame.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

  typedef struct packed {
    logic long_frame;
    logic launch_fall;
    logic sq_sync;
  } ftx_mode_t;

  // A sync request is honoured in short frames and in the square format.
  function automatic logic sync_allowed(input ftx_mode_t m);
    return !m.long_frame || m.sq_sync;
  endfunction

endpackage

// File: rtl/ftx_rst_sync.sv
module ftx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/ftx_seq.sv
module ftx_seq
  import ftx_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ftx_mode_t        mode,
  input  logic             sync_in,
  output logic             ph_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             launch_o,
  output logic             wrap_o,
  output logic             accept_o,
  output logic             filt_restart_o
);

  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(2 * WORD_W - 1);

  logic             ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;
  logic             frst_q, frst_d;
  logic [CNT_W-1:0] last_idx;
  logic             launch, accept, wrap;

  always_comb begin
    last_idx = mode.long_frame ? LAST_LONG : LAST_SHORT;
    launch   = !ph_q;
    accept   = sync_in && sync_allowed(mode) && !first_q;
    wrap     = launch && (cnt_q >= last_idx) && !accept;

    ph_d     = accept ? 1'b0 : !ph_q;
    first_d  = first_q || accept;
    frst_d   = accept;

    if (accept)      cnt_d = last_idx;
    else if (wrap)   cnt_d = '0;
    else if (launch) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= 1'b0;
      cnt_q   <= '1;
      first_q <= 1'b0;
      frst_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
      frst_q  <= frst_d;
    end
  end

  assign ph_o           = ph_q;
  assign cnt_o          = cnt_q;
  assign launch_o       = launch;
  assign wrap_o         = wrap;
  assign accept_o       = accept;
  assign filt_restart_o = frst_q;

endmodule

// File: rtl/ftx_shift.sv
module ftx_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] res_data,
  input  logic              res_valid,
  input  logic              load,
  input  logic              shift,
  output logic              msb_o
);

  logic [WORD_W-1:0] stage_q, stage_d;
  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb begin
    stage_d = res_valid ? res_data : stage_q;
    if (load)       sh_d = stage_q;
    else if (shift) sh_d = {sh_q[WORD_W-2:0], 1'b0};
    else            sh_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      sh_q    <= '0;
    end else begin
      stage_q <= stage_d;
      sh_q    <= sh_d;
    end
  end

  assign msb_o = sh_q[WORD_W-1];

endmodule

// File: rtl/ftx_settle.sv
module ftx_settle #(
  parameter int unsigned FRAMES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic wrap,
  output logic settling_o
);

  localparam int unsigned SW = $clog2(FRAMES + 2);
  localparam logic [SW-1:0] LOAD_VAL = SW'(FRAMES + 1);

  logic [SW-1:0] left_q, left_d;

  always_comb begin
    if (restart)                    left_d = LOAD_VAL;
    else if (wrap && left_q != '0)  left_d = left_q - 1'b1;
    else                            left_d = left_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign settling_o = (left_q != '0);

endmodule

// File: rtl/frame_serial_tx.sv
module frame_serial_tx
  import ftx_pkg::*;
#(
  parameter int unsigned WORD_W        = 16,
  parameter int unsigned SETTLE_FRAMES = 4,
  parameter int unsigned RST_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] res_data,
  input  logic              res_valid,
  input  logic              long_frame,
  input  logic              launch_fall,
  input  logic              sq_sync,
  input  logic              sync_in,
  input  logic              line_sel,
  input  logic              slot_id,
  output logic              bit_clk,
  output logic              ser_data,
  output logic              ser_oe,
  output logic              frame_sync,
  output logic              filt_restart,
  output logic              settling
);

  localparam int unsigned CNT_W = $clog2(2 * WORD_W);
  localparam logic [CNT_W-1:0] WORD_IDX = CNT_W'(WORD_W);

  ftx_mode_t        mode;
  logic             rst_n_i;
  logic             ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             launch, wrap, accept;
  logic             sh_msb;
  logic             in_word;

  assign mode = '{long_frame: long_frame, launch_fall: launch_fall, sq_sync: sq_sync};

  ftx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_i)
  );

  ftx_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n_i),
    .mode           (mode),
    .sync_in        (sync_in),
    .ph_o           (ph_q),
    .cnt_o          (cnt_q),
    .launch_o       (launch),
    .wrap_o         (wrap),
    .accept_o       (accept),
    .filt_restart_o (filt_restart)
  );

  ftx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .res_data  (res_data),
    .res_valid (res_valid),
    .load      (wrap),
    .shift     (launch && !wrap && !accept),
    .msb_o     (sh_msb)
  );

  ftx_settle #(.FRAMES(SETTLE_FRAMES)) u_settle (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .restart    (accept),
    .wrap       (wrap),
    .settling_o (settling)
  );

  always_comb begin
    in_word    = (cnt_q < WORD_IDX);
    bit_clk    = ph_q ^ mode.launch_fall;
    ser_data   = in_word && sh_msb;
    ser_oe     = (line_sel == slot_id);
    if (mode.long_frame && mode.sq_sync) frame_sync = !in_word;
    else                                 frame_sync = (cnt_q == '0);
  end

endmodule

// File: rtl/ftx_chk.sv
module ftx_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 5
) (
  input logic             clk,
  input logic             rst_n_i,
  input logic             sync_in,
  input logic             long_frame,
  input logic             sq_sync,
  input logic             ph_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ser_data,
  input logic             filt_restart,
  input logic             settling
);

  localparam logic [CNT_W-1:0] WORD_IDX = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] L_SHORT  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] L_LONG   = CNT_W'(2 * WORD_W - 1);

  logic             seen_q;
  logic [CNT_W-1:0] lim;

  assign lim = long_frame ? L_LONG : L_SHORT;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)          seen_q <= 1'b0;
    else if (filt_restart) seen_q <= 1'b1;
  end

  p_phase_alt_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    !sync_in |=> (ph_q != $past(ph_q)));

  p_hold_half_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ph_q && !sync_in) |=> $stable(cnt_q));

  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!ph_q && !sync_in && cnt_q >= lim) |=> (cnt_q == '0));

  p_tail_zero_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cnt_q >= WORD_IDX) |-> !ser_data);

  p_pulse_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (long_frame && !sq_sync && sync_in) |=> !filt_restart);

  p_one_restart_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    seen_q |-> !filt_restart);

  p_settle_rise_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    filt_restart |-> settling);

endmodule

bind frame_serial_tx ftx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n_i      (rst_n_i),
  .sync_in      (sync_in),
  .long_frame   (long_frame),
  .sq_sync      (sq_sync),
  .ph_q         (ph_q),
  .cnt_q        (cnt_q),
  .ser_data     (ser_data),
  .filt_restart (filt_restart),
  .settling     (settling)
);

// File: tb/tb_frame_serial_tx.sv
`timescale 1ns/1ps
module tb_frame_serial_tx;

  localparam int SETTLE = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] res_data;
  logic        res_valid, long_frame, launch_fall, sq_sync, sync_in, line_sel, slot_id;
  logic        bit_clk, ser_data, ser_oe, frame_sync, filt_restart, settling;

  int n_tests = 0;
  int n_fail  = 0;
  logic pb_prev = 1'b0, pb_cur = 1'b0;
  logic [15:0] last_word;

  always #2.5 clk = ~clk;

  frame_serial_tx dut (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
    .long_frame(long_frame), .launch_fall(launch_fall), .sq_sync(sq_sync),
    .sync_in(sync_in), .line_sel(line_sel), .slot_id(slot_id),
    .bit_clk(bit_clk), .ser_data(ser_data), .ser_oe(ser_oe),
    .frame_sync(frame_sync), .filt_restart(filt_restart), .settling(settling)
  );

  // {long_frame, sq_sync, launch_fall, word}
  localparam logic [18:0] VEC [6] = '{
    {3'b000, 16'hA5C3},
    {3'b011, 16'h8001},
    {3'b100, 16'h7E18},
    {3'b110, 16'hFFFF},
    {3'b111, 16'h0001},
    {3'b101, 16'h5A5A}
  };

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic chk(input string req, input string note, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, note, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    pb_prev = pb_cur;
    pb_cur  = bit_clk;
  endtask

  function automatic logic launched(input logic lf);
    return (pb_cur != pb_prev) && (pb_cur == !lf);
  endfunction

  task automatic wait_start(input logic lg, input logic sq, input logic lf);
    logic prevf = 1'b0;
    logic sqe = lg && sq;
    for (int k = 0; k < 300; k++) begin
      step();
      if (launched(lf)) begin
        if (sqe ? (prevf && !frame_sync) : frame_sync) return;
        prevf = frame_sync;
      end
    end
    chk("R2", "no frame start seen", 32'd0, 32'd1);
  endtask

  // Current negedge must be the launch of bit period 0.
  task automatic collect_frame(input logic lg, input logic sq, input logic lf,
                               input logic [15:0] word, input string note,
                               input int inj_at, input logic [15:0] inj_word);
    int          len = lg ? 32 : 16;
    logic        sqe = lg && sq;
    logic        edge_ok = 1'b1;
    logic        len_ok;
    logic [31:0] got_d = '0, got_f = '0;
    for (int i = 0; i < len; i++) begin
      if (i > 0) begin
        step();
        if (!launched(lf)) edge_ok = 1'b0;
      end
      got_d[31-i] = ser_data;
      got_f[31-i] = frame_sync;
      if (i == inj_at) begin
        res_data  = inj_word;
        res_valid = 1'b1;
      end
      step();
      res_valid = 1'b0;
      if (launched(lf) || ser_data !== got_d[31-i] || frame_sync !== got_f[31-i]) edge_ok = 1'b0;
    end
    step();
    len_ok = launched(lf) && (sqe ? !frame_sync : frame_sync);
    last_word = got_d[31:16];
    chk("R1", note, {16'h0, got_d[31:16]}, {16'h0, word});
    if (lg) chk("R3", note, {16'h0, got_d[15:0]}, 32'h0);
    chk("R5", note, got_f, sqe ? 32'h0000FFFF : 32'h80000000);
    chk("R4", note, {31'h0, edge_ok}, 32'h1);
    chk("R2", note, {31'h0, len_ok}, 32'h1);
  endtask

  task automatic run_frame(input logic lg, input logic sq, input logic lf,
                           input logic [15:0] word, input string note);
    wait_start(lg, sq, lf);
    collect_frame(lg, sq, lf, word, note, -1, 16'h0);
  endtask

  task automatic set_mode(input logic lg, input logic sq, input logic lf);
    long_frame = lg; sq_sync = sq; launch_fall = lf;
  endtask

  task automatic stage(input logic [15:0] w);
    res_data = w; res_valid = 1'b1;
    step();
    res_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_mode(1'b0, 1'b0, 1'b0);
    repeat (3) step();
    chk("R12", "bit_clk in reset", {31'h0, bit_clk}, 32'h0);
    chk("R12", "ser_data in reset", {31'h0, ser_data}, 32'h0);
    chk("R12", "frame_sync in reset", {31'h0, frame_sync}, 32'h0);
    chk("R12", "restart/settling in reset", {30'h0, filt_restart, settling}, 32'h0);
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL WDOG: actual running expected done");
    report();
    $finish;
  end

  initial begin
    int n;
    logic prevf;
    rst_n = 1'b0; res_data = '0; res_valid = 1'b0; sync_in = 1'b0;
    line_sel = 1'b0; slot_id = 1'b0;
    set_mode(1'b0, 1'b0, 1'b0);

    do_reset();

    // Table of mode/word vectors
    for (int v = 0; v < 6; v++) begin
      set_mode(VEC[v][18], VEC[v][17], VEC[v][16]);
      stage(VEC[v][15:0]);
      run_frame(VEC[v][18], VEC[v][17], VEC[v][16], VEC[v][15:0], $sformatf("vector %0d", v));
    end

    // R11: no new result -> retransmit
    run_frame(1'b1, 1'b0, 1'b1, 16'h5A5A, "R11 repeat");
    chk("R11", "repeat word", {16'h0, last_word}, 32'h5A5A);

    // R13: result mid-frame waits for next frame
    set_mode(1'b0, 1'b0, 1'b0);
    stage(16'h3C69);
    wait_start(1'b0, 1'b0, 1'b0);
    collect_frame(1'b0, 1'b0, 1'b0, 16'h3C69, "R13 current", 6, 16'hC396);
    chk("R13", "current frame kept", {16'h0, last_word}, 32'h3C69);
    collect_frame(1'b0, 1'b0, 1'b0, 16'hC396, "R13 next", -1, 16'h0);
    chk("R13", "next frame new word", {16'h0, last_word}, 32'hC396);

    // R8: ignored sync in long pulse mode
    do_reset();
    set_mode(1'b1, 1'b0, 1'b0);
    stage(16'h9C31);
    run_frame(1'b1, 1'b0, 1'b0, 16'h9C31, "R8 setup");
    wait_start(1'b1, 1'b0, 1'b0);
    repeat (6) step();
    sync_in = 1'b1;
    step();
    sync_in = 1'b0;
    chk("R8", "restart after ignored sync", {31'h0, filt_restart}, 32'h0);
    chk("R8", "settling after ignored sync", {31'h0, settling}, 32'h0);
    run_frame(1'b1, 1'b0, 1'b0, 16'h9C31, "R8 undisturbed");

    // R6 and R10: first accepted sync in square format
    set_mode(1'b1, 1'b1, 1'b0);
    run_frame(1'b1, 1'b1, 1'b0, 16'h9C31, "square setup");
    wait_start(1'b1, 1'b1, 1'b0);
    repeat (6) step();
    sync_in = 1'b1;
    step();
    sync_in = 1'b0;
    chk("R6", "filt_restart pulse", {31'h0, filt_restart}, 32'h1);
    chk("R6", "bit_clk idle after sync", {31'h0, bit_clk}, 32'h0);
    chk("R10", "settling rises", {31'h0, settling}, 32'h1);
    step();
    chk("R6", "restart frame starts", {30'h0, launched(1'b0), frame_sync}, 32'h2);
    chk("R6", "filt_restart one cycle", {31'h0, filt_restart}, 32'h0);
    collect_frame(1'b1, 1'b1, 1'b0, 16'h9C31, "R6 restarted frame", -1, 16'h0);
    wait_start(1'b1, 1'b1, 1'b0);
    wait_start(1'b1, 1'b1, 1'b0);
    chk("R10", "settling still high", {31'h0, settling}, 32'h1);
    wait_start(1'b1, 1'b1, 1'b0);
    chk("R10", $sformatf("settling low after %0d frames", SETTLE), {31'h0, settling}, 32'h0);

    // R7: later sync leaves timing alone
    repeat (10) step();
    prevf = frame_sync;
    sync_in = 1'b1;
    step();
    sync_in = 1'b0;
    n = 1;
    chk("R7", "no second restart", {31'h0, filt_restart}, 32'h0);
    for (int k = 0; k < 200; k++) begin
      if (launched(1'b0)) begin
        if (prevf && !frame_sync) break;
        prevf = frame_sync;
      end
      step();
      n++;
    end
    chk("R7", "steps to next frame start", n, 32'd54);

    // R9: shared-line enable
    for (int c = 0; c < 4; c++) begin
      line_sel = c[1]; slot_id = c[0];
      #1;
      chk("R9", $sformatf("sel=%0d id=%0d", c[1], c[0]), {31'h0, ser_oe}, {31'h0, c[1] == c[0]});
    end

    report();
    $finish;
  end

endmodule